// File: doc/BRIEF.md
# Configurable-Trigger Interrupt Aggregator

This block collects up to 32 interrupt sources into one request line for a parent controller. Each source is first brought into the local clock domain. It is then qualified by a per-source choice of edge or level detection and of active polarity. The result sets a bit in a pending register. Software clears pending bits by writing ones to them. It can also raise any pending bit on purpose through a force register.

An enable mask selects which pending bits count toward the output. The OR of the enabled pending bits drives the output line. The line is either a level or a single-cycle pulse, and either active-high or active-low, as two output control registers select. All control goes through a simple word-addressed read/write port. Reads return data one cycle after the request.

Top module: `irq_merge_ctrl`

## Requirements
- R1: After reset the enable, source-mode, source-polarity, output-mode, output-polarity and read-data values are all 0, and irq_out is 1, which is the idle value of an active-low level output.
- R2: Registers sit at byte offsets, decoded from address bits [4:2] with bits [1:0] ignored: enable 0x00, pending 0x04, source mode 0x08, source polarity 0x0C, output mode 0x10, output polarity 0x14, force 0x18. A read request returns its data on reg_rdata in the cycle after the request. Any other offset reads as 0. Output mode and output polarity each hold bit 0 only.
- R3: A source whose mode bit is 1 is edge-detected after a two-flop synchroniser. Polarity 1 sets its pending bit on a 0-to-1 transition of the input, and polarity 0 sets it on a 1-to-0 transition. The opposite transition has no effect.
- R4: A source whose mode bit is 0 is level-detected. Polarity 1 means active-high and polarity 0 means active-low. Its pending bit is set in every cycle the synchronised level is active, so a clear written while the level is active leaves the bit at 1.
- R5: Writing the pending register clears each bit written as 1 and leaves each bit written as 0 unchanged. A set in the same cycle wins over the clear.
- R6: Writing a 1 to a force bit sets the matching pending bit, exactly as a detected event would. The force register always reads as 0.
- R7: Only pending bits whose enable bit is 1 can make the output active. With no enabled pending bit, irq_out stays at its idle value.
- R8: With output mode 0, irq_out is active while any enabled pending bit is 1. Output polarity 1 makes the active value 1, and polarity 0 makes the active value 0. irq_out follows the pending and enable state one cycle later.
- R9: With output mode 1, irq_out is active for exactly one cycle when the set of enabled pending bits goes from empty to non-empty. Further events while some bit is still pending give no further pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_in | input | NUM_SRC | Raw interrupt source inputs |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Register byte address |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data, valid the cycle after reg_rd |
| irq_out | output | 1 | Aggregated interrupt toward the parent controller |

## Verification
The bench builds the block with its defaults: 32 sources, a 32-bit data path and a 5-bit address. At that size the top source bit and a full all-ones clear write are both in reach, and so is the offset just past the force register. Different sources are given different trigger settings in the same run, so rising and falling edges, levels of both polarities and forced bits all interact in the one pending register. The output is then observed in each of its mode and polarity combinations.

// File: rtl/irqm_pkg.sv
package irqm_pkg;

  typedef enum logic [2:0] {
    RI_ENABLE   = 3'd0,
    RI_PENDING  = 3'd1,
    RI_SRC_MODE = 3'd2,
    RI_SRC_POL  = 3'd3,
    RI_OUT_MODE = 3'd4,
    RI_OUT_POL  = 3'd5,
    RI_FORCE    = 3'd6,
    RI_UNUSED   = 3'd7
  } reg_idx_e;

  localparam int unsigned IDX_LSB = 2;
  localparam int unsigned IDX_W   = 3;

endpackage

// File: rtl/irqm_sync.sv
module irqm_sync #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);

  logic [WIDTH-1:0] stage1_q;
  logic [WIDTH-1:0] stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= async_in;
      stage2_q <= stage1_q;
    end
  end

  assign sync_out = stage2_q;

endmodule

// File: rtl/irqm_detect.sv
module irqm_detect #(
  parameter int unsigned NUM_SRC = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] lvl,
  input  logic [NUM_SRC-1:0] trig_mode,
  input  logic [NUM_SRC-1:0] trig_pol,
  output logic [NUM_SRC-1:0] hit
);

  logic [NUM_SRC-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= lvl;
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    logic rise;
    logic fall;
    logic edge_hit;
    logic lvl_hit;
    assign rise     = lvl[i] & ~prev_q[i];
    assign fall     = ~lvl[i] & prev_q[i];
    assign edge_hit = trig_pol[i] ? rise : fall;
    assign lvl_hit  = (lvl[i] == trig_pol[i]);
    assign hit[i]   = trig_mode[i] ? edge_hit : lvl_hit;
  end

endmodule

// File: rtl/irqm_regs.sv
module irqm_regs
  import irqm_pkg::*;
#(
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ADDR_W  = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  input  logic [NUM_SRC-1:0] hit,
  output logic [DATA_W-1:0]  reg_rdata,
  output logic [NUM_SRC-1:0] enable_q,
  output logic [NUM_SRC-1:0] pending_q,
  output logic [NUM_SRC-1:0] src_mode_q,
  output logic [NUM_SRC-1:0] src_pol_q,
  output logic               out_mode_q,
  output logic               out_pol_q
);

  localparam int unsigned HI_LSB = IDX_LSB + IDX_W;

  reg_idx_e           idx;
  logic               hi_zero;
  logic [NUM_SRC-1:0] wmask;
  logic [NUM_SRC-1:0] clr_vec;
  logic [NUM_SRC-1:0] frc_vec;
  logic [NUM_SRC-1:0] pending_d;
  logic               en_we;
  logic               mode_we;
  logic               pol_we;
  logic               omode_we;
  logic               opol_we;
  logic [DATA_W-1:0]  rdata_d;

  assign hi_zero = ((reg_addr >> HI_LSB) == '0);
  assign idx     = hi_zero ? reg_idx_e'(reg_addr[HI_LSB-1:IDX_LSB]) : RI_UNUSED;
  assign wmask   = reg_wdata[NUM_SRC-1:0];

  always_comb begin
    en_we    = reg_wr && (idx == RI_ENABLE);
    mode_we  = reg_wr && (idx == RI_SRC_MODE);
    pol_we   = reg_wr && (idx == RI_SRC_POL);
    omode_we = reg_wr && (idx == RI_OUT_MODE);
    opol_we  = reg_wr && (idx == RI_OUT_POL);
    clr_vec  = (reg_wr && (idx == RI_PENDING)) ? wmask : '0;
    frc_vec  = (reg_wr && (idx == RI_FORCE))   ? wmask : '0;
    // set sources take priority over a clear in the same cycle
    pending_d = (pending_q & ~clr_vec) | hit | frc_vec;
  end

  always_comb begin
    rdata_d = '0;
    unique case (idx)
      RI_ENABLE:   rdata_d[NUM_SRC-1:0] = enable_q;
      RI_PENDING:  rdata_d[NUM_SRC-1:0] = pending_q;
      RI_SRC_MODE: rdata_d[NUM_SRC-1:0] = src_mode_q;
      RI_SRC_POL:  rdata_d[NUM_SRC-1:0] = src_pol_q;
      RI_OUT_MODE: rdata_d[0]           = out_mode_q;
      RI_OUT_POL:  rdata_d[0]           = out_pol_q;
      default:     rdata_d              = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable_q   <= '0;
      pending_q  <= '0;
      src_mode_q <= '0;
      src_pol_q  <= '0;
      out_mode_q <= 1'b0;
      out_pol_q  <= 1'b0;
      reg_rdata  <= '0;
    end else begin
      pending_q <= pending_d;
      if (en_we)    enable_q   <= wmask;
      if (mode_we)  src_mode_q <= wmask;
      if (pol_we)   src_pol_q  <= wmask;
      if (omode_we) out_mode_q <= reg_wdata[0];
      if (opol_we)  out_pol_q  <= reg_wdata[0];
      if (reg_rd)   reg_rdata  <= rdata_d;
    end
  end

endmodule

// File: rtl/irqm_outshape.sv
module irqm_outshape (
  input  logic clk,
  input  logic rst_n,
  input  logic pend_any,
  input  logic pulse_mode,
  input  logic active_high,
  output logic irq_out
);

  logic pend_prev_q;
  logic irq_q;
  logic active;
  logic irq_d;

  always_comb begin
    active = pulse_mode ? (pend_any & ~pend_prev_q) : pend_any;
    irq_d  = active_high ? active : ~active;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_prev_q <= 1'b0;
      irq_q       <= 1'b1;
    end else begin
      pend_prev_q <= pend_any;
      irq_q       <= irq_d;
    end
  end

  assign irq_out = irq_q;

endmodule

// File: rtl/irq_merge_ctrl.sv
module irq_merge_ctrl #(
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ADDR_W  = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_in,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  output logic               irq_out
);

  logic [1:0]         rst_pipe_q;
  logic               rst_int_n;
  logic [NUM_SRC-1:0] src_sync;
  logic [NUM_SRC-1:0] hit_vec;
  logic [NUM_SRC-1:0] enable_vec;
  logic [NUM_SRC-1:0] status_vec;
  logic [NUM_SRC-1:0] mode_vec;
  logic [NUM_SRC-1:0] pol_vec;
  logic               out_mode_q;
  logic               out_pol_q;
  logic               pend_any;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  irqm_sync #(.WIDTH(NUM_SRC)) u_sync (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .async_in (src_in),
    .sync_out (src_sync)
  );

  irqm_detect #(.NUM_SRC(NUM_SRC)) u_detect (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .lvl       (src_sync),
    .trig_mode (mode_vec),
    .trig_pol  (pol_vec),
    .hit       (hit_vec)
  );

  irqm_regs #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .reg_wr     (reg_wr),
    .reg_rd     (reg_rd),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .hit        (hit_vec),
    .reg_rdata  (reg_rdata),
    .enable_q   (enable_vec),
    .pending_q  (status_vec),
    .src_mode_q (mode_vec),
    .src_pol_q  (pol_vec),
    .out_mode_q (out_mode_q),
    .out_pol_q  (out_pol_q)
  );

  assign pend_any = |(status_vec & enable_vec);

  irqm_outshape u_out (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .pend_any    (pend_any),
    .pulse_mode  (out_mode_q),
    .active_high (out_pol_q),
    .irq_out     (irq_out)
  );

endmodule

// File: rtl/irqm_checks.sv
module irqm_checks
  import irqm_pkg::*;
#(
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ADDR_W  = 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic               reg_wr,
  input logic               reg_rd,
  input logic [ADDR_W-1:0]  reg_addr,
  input logic [DATA_W-1:0]  reg_wdata,
  input logic [DATA_W-1:0]  reg_rdata,
  input logic               irq_out,
  input logic [NUM_SRC-1:0] status_vec,
  input logic [NUM_SRC-1:0] enable_vec,
  input logic               out_mode,
  input logic               out_pol
);

  logic               at_low;
  logic [2:0]         a_idx;
  logic [NUM_SRC-1:0] wm;
  logic [NUM_SRC-1:0] clr_mask;
  logic               frc_wr;

  assign at_low   = ((reg_addr >> (IDX_LSB + IDX_W)) == '0);
  assign a_idx    = reg_addr[IDX_LSB+IDX_W-1:IDX_LSB];
  assign wm       = reg_wdata[NUM_SRC-1:0];
  assign frc_wr   = reg_wr && at_low && (a_idx == 3'd6);
  assign clr_mask = (reg_wr && at_low && (a_idx == 3'd1)) ? wm : '0;

  // R5: a pending bit only drops on a clear write of that bit
  a_r5_no_spurious_clear: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(status_vec) & ~status_vec & ~$past(clr_mask)) == '0));

  // R6: forced bits are pending the cycle after the write
  a_r6_force_sets: assert property (@(posedge clk) disable iff (!rst_n)
    frc_wr |=> ((status_vec & $past(wm)) == $past(wm)));

  // R6: force register reads back as zero
  a_r6_force_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && at_low && (a_idx == 3'd6)) |=> (reg_rdata == '0));

  // R2: unmapped offset reads as zero
  a_r2_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && !(at_low && a_idx != 3'd7)) |=> (reg_rdata == '0));

  // R7: nothing enabled means idle output in level mode
  a_r7_masked_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (enable_vec == '0 && !out_mode && !reg_wr) |=> (irq_out == !$past(out_pol)));

  // R9: an active-high pulse lasts a single cycle
  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (out_mode && out_pol && irq_out && !reg_wr) |=> !irq_out);

endmodule

bind irq_merge_ctrl irqm_checks #(
  .NUM_SRC (NUM_SRC),
  .DATA_W  (DATA_W),
  .ADDR_W  (ADDR_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .reg_wr     (reg_wr),
  .reg_rd     (reg_rd),
  .reg_addr   (reg_addr),
  .reg_wdata  (reg_wdata),
  .reg_rdata  (reg_rdata),
  .irq_out    (irq_out),
  .status_vec (status_vec),
  .enable_vec (enable_vec),
  .out_mode   (out_mode_q),
  .out_pol    (out_pol_q)
);

// File: tb/irq_merge_ctrl_test.sv
module irq_merge_ctrl_test;

  localparam int unsigned NS = 32;

  localparam logic [4:0] A_EN   = 5'h00;
  localparam logic [4:0] A_PEND = 5'h04;
  localparam logic [4:0] A_MODE = 5'h08;
  localparam logic [4:0] A_POL  = 5'h0C;
  localparam logic [4:0] A_OMOD = 5'h10;
  localparam logic [4:0] A_OPOL = 5'h14;
  localparam logic [4:0] A_FRC  = 5'h18;
  localparam logic [4:0] A_GAP  = 5'h1C;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NS-1:0] src = '0;
  logic          reg_wr = 1'b0;
  logic          reg_rd = 1'b0;
  logic [4:0]    reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic          irq_out;

  int checks = 0;
  int errors = 0;

  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_seen = 1'b0;

  always #2 clk = ~clk;

  irq_merge_ctrl uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_in    (src),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .irq_out   (irq_out)
  );

  // monitor: compare read data against the scoreboard queue
  always @(posedge clk) rd_seen <= reg_rd;

  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL %s unexpected read data %h", "R2", reg_rdata);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if (reg_rdata !== e) begin
          errors++;
          $display("FAIL %s read actual %h expected %h", t, reg_rdata, e);
        end
      end
    end
  end

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_exp(input logic [4:0] a, input logic [31:0] e, input string t);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic chk_irq(input logic e, input string t);
    checks++;
    if (irq_out !== e) begin
      errors++;
      $display("FAIL %s irq_out actual %b expected %b", t, irq_out, e);
    end
  endtask

  task automatic count_pulses(input logic e_cnt, input string t);
    int n = 0;
    for (int i = 0; i < 6; i++) begin
      if (irq_out === 1'b1) n++;
      @(negedge clk);
    end
    checks++;
    if (n != int'(e_cnt)) begin
      errors++;
      $display("FAIL %s pulse count actual %0d expected %0d", t, n, e_cnt);
    end
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(4);

    // R1: reset values
    rd_exp(A_EN,   32'h0, "R1");
    rd_exp(A_MODE, 32'h0, "R1");
    rd_exp(A_POL,  32'h0, "R1");
    rd_exp(A_OMOD, 32'h0, "R1");
    rd_exp(A_OPOL, 32'h0, "R1");
    chk_irq(1'b1, "R1");

    // R4: default active-low level with all inputs low -> all pending
    rd_exp(A_PEND, 32'hFFFF_FFFF, "R4");

    // R2: register readback and unmapped offset
    wr(A_POL, 32'hFFFF_FFFF);          // all active-high level
    wr(A_PEND, 32'hFFFF_FFFF);         // R5 clear all
    rd_exp(A_PEND, 32'h0, "R5");
    wr(A_EN, 32'hA5A5_0000);
    rd_exp(A_EN, 32'hA5A5_0000, "R2");
    wr(A_OPOL, 32'hFFFF_FFFF);
    rd_exp(A_OPOL, 32'h1, "R2");
    wr(A_OPOL, 32'h0);
    wr(A_EN, 32'h0);
    rd_exp(A_GAP, 32'h0, "R2");
    rd_exp(A_FRC, 32'h0, "R6");

    // R4: active-high level, clear ignored while active
    src[3] = 1'b1;
    idle(5);
    rd_exp(A_PEND, 32'h0000_0008, "R4");
    wr(A_PEND, 32'h0000_0008);
    rd_exp(A_PEND, 32'h0000_0008, "R4");
    src[3] = 1'b0;
    idle(5);
    wr(A_PEND, 32'h0000_0008);
    rd_exp(A_PEND, 32'h0, "R4");

    // R3: bit4 rising edge, bit5 falling edge; top bit rising edge
    wr(A_MODE, 32'h8000_0030);
    wr(A_POL,  32'hFFFF_FFDF);
    wr(A_PEND, 32'hFFFF_FFFF);
    rd_exp(A_PEND, 32'h0, "R3");
    src[4] = 1'b1;
    idle(5);
    rd_exp(A_PEND, 32'h0000_0010, "R3");
    src[4] = 1'b0;
    idle(5);
    rd_exp(A_PEND, 32'h0000_0010, "R3");
    wr(A_PEND, 32'h0000_0010);
    rd_exp(A_PEND, 32'h0, "R5");
    src[5] = 1'b1;
    idle(5);
    rd_exp(A_PEND, 32'h0, "R3");
    src[5] = 1'b0;
    idle(5);
    rd_exp(A_PEND, 32'h0000_0020, "R3");
    wr(A_PEND, 32'h0);
    rd_exp(A_PEND, 32'h0000_0020, "R5");
    src[31] = 1'b1;
    idle(5);
    rd_exp(A_PEND, 32'h8000_0020, "R3");
    wr(A_PEND, 32'h8000_0020);
    rd_exp(A_PEND, 32'h0, "R5");

    // R6: force sets pending on a level source with inactive input
    wr(A_FRC, 32'h0000_0100);
    rd_exp(A_PEND, 32'h0000_0100, "R6");
    rd_exp(A_FRC, 32'h0, "R6");
    wr(A_PEND, 32'h0000_0100);
    rd_exp(A_PEND, 32'h0, "R6");

    // R7 / R8: masking and level output polarity
    wr(A_EN, 32'h0000_0010);
    idle(2);
    chk_irq(1'b1, "R8");
    wr(A_FRC, 32'h0000_0001);
    idle(2);
    chk_irq(1'b1, "R7");
    wr(A_PEND, 32'h0000_0001);
    wr(A_FRC, 32'h0000_0010);
    idle(2);
    chk_irq(1'b0, "R8");
    wr(A_OPOL, 32'h1);
    idle(2);
    chk_irq(1'b1, "R8");
    wr(A_PEND, 32'h0000_0010);
    idle(2);
    chk_irq(1'b0, "R8");

    // R9: pulse output
    wr(A_OMOD, 32'h1);
    idle(2);
    wr(A_FRC, 32'h0000_0010);
    count_pulses(1'b1, "R9");
    wr(A_FRC, 32'h0000_0010);
    count_pulses(1'b0, "R9");
    wr(A_PEND, 32'h0000_0010);
    idle(2);
    wr(A_FRC, 32'h0000_0010);
    count_pulses(1'b1, "R9");

    idle(4);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R2 reads outstanding actual %0d expected 0", exp_q.size());
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule